// File: doc/BRIEF.md
# Flash Write Status Generator

This block sits in the read path of a byte-wide flash controller and stands in for the array data while an internal program or erase is running. A one-cycle start pulse carries the operation kind and, for a program, the byte being written. From that pulse a down-counter models the worst-case operation time in clock cycles, and a busy flag stays high for exactly that long.

While busy, each read returns two status bits in place of the top two data bits. The most significant bit is a polarity flag: the inverse of the written bit for a program, and zero for an erase. The bit below it flips on every read. The six low bits pass the array data through. Once busy drops, reads return the array byte unchanged. An erased region already reads back FFh, so the polarity bit then reads 1.

The durations are set as microsecond parameters together with the clock rate in kHz. The defaults give 20 µs for a byte program, 25 ms for a sector erase and 100 ms for a chip erase. Command decoding and the storage array live outside this block.

Top module: `flash_wstat_gen`

## Requirements
- R1: During and right after reset, `busy` is 0 and `rd_data` is 00h.
- R2: While a program is running (op code 0), bit 7 of each read returns the inverse of bit 7 of the byte given with the start pulse.
- R3: While an erase is running (op code 1 for a sector, 2 or 3 for the whole chip), bit 7 of each read returns 0.
- R4: While busy, bit 6 of the first read after a start is 0, and each later read in the same operation returns the opposite of the previous one.
- R5: While busy, bits 5 to 0 of each read equal the array data presented with that read.
- R6: `busy` rises on the clock edge that samples an accepted start. It stays high for exactly N cycles, where N = CLK_KHZ × duration_us / 1000 for the chosen op.
- R7: A start pulse that arrives while `busy` is high is ignored: the running op, its data bit and its end time are unchanged, and the toggle keeps its sequence.
- R8: A read while `busy` is low returns the full array byte. This includes the first read after busy falls, so a completed erase reads back FFh from an erased region.
- R9: `rd_data` is registered. It takes its new value on the edge that samples `rd_en` and holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch of an internal operation |
| start_op | input | 2 | Operation kind: 0 program, 1 sector erase, 2 or 3 chip erase |
| start_data | input | DATA_W | Byte being programmed (bit 7 used) |
| rd_en | input | 1 | Read strobe |
| arr_data | input | DATA_W | Data read from the array |
| rd_data | output | DATA_W | Registered read data or status word |
| busy | output | 1 | High while the modelled operation runs |

## Verification
A read result is due one edge after the `rd_en` that asks for it. `busy` changes on the edge that samples the accepted start, and again on the edge that ends the Nth busy cycle. The bench drives its inputs on the falling edge. It advances its own cycle model on the rising edge and compares both outputs on the next falling edge, so each compare sees exactly the registers one edge has updated. The busy-length check counts busy cycles per operation and compares the count at the fall.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_CHIP  = 2'd2,
    OP_CHIP2 = 2'd3
  } op_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
endpackage

// File: rtl/fws_timer.sv
module fws_timer
  import fws_pkg::*;
#(
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 40,
  parameter int unsigned CHIP_CYC = 80,
  localparam int CNT_W = $clog2(CHIP_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  op_e  op,
  output logic busy
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (op)
      OP_PROG: load_val = CNT_W'(PROG_CYC - 1);
      OP_SECT: load_val = CNT_W'(SECT_CYC - 1);
      default: load_val = CNT_W'(CHIP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fws_status.sv
module fws_status
  import fws_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  op_e  op,
  input  logic wr_bit7,
  input  logic rd_en,
  input  logic busy,
  output logic poll_bit,
  output logic tog_bit
);
  logic is_prog;
  logic inv_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_prog <= 1'b0;
      inv_bit <= 1'b0;
      tog_bit <= 1'b0;
    end else if (launch) begin
      is_prog <= (op == OP_PROG);
      inv_bit <= ~wr_bit7;
      tog_bit <= 1'b0;
    end else if (rd_en && busy) begin
      tog_bit <= ~tog_bit;
    end
  end

  assign poll_bit = is_prog ? inv_bit : 1'b0;
endmodule

// File: rtl/fws_rdmux.sv
module fws_rdmux
  import fws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              poll_bit,
  input  logic              tog_bit,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word           = arr_data;
    status_word[POLL_BIT] = poll_bit;
    status_word[TOG_BIT]  = tog_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= busy ? status_word : arr_data;
  end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import fws_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned PROG_US = 20,
  parameter int unsigned SECT_US = 25000,
  parameter int unsigned CHIP_US = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        start_op,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int unsigned PROG_CYC = int'((64'(CLK_KHZ) * 64'(PROG_US)) / 64'd1000);
  localparam int unsigned SECT_CYC = int'((64'(CLK_KHZ) * 64'(SECT_US)) / 64'd1000);
  localparam int unsigned CHIP_CYC = int'((64'(CLK_KHZ) * 64'(CHIP_US)) / 64'd1000);

  logic launch;
  logic poll_bit;
  logic tog_bit;
  op_e  op;

  assign op     = op_e'(start_op);
  assign launch = start && !busy;

  fws_timer #(
    .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .launch(launch),
    .op    (op),
    .busy  (busy)
  );

  fws_status u_status (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .op      (op),
    .wr_bit7 (start_data[POLL_BIT]),
    .rd_en   (rd_en),
    .busy    (busy),
    .poll_bit(poll_bit),
    .tog_bit (tog_bit)
  );

  fws_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .busy    (busy),
    .poll_bit(poll_bit),
    .tog_bit (tog_bit),
    .arr_data(arr_data),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int          DATA_W  = 8,
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned PROG_US = 20,
  parameter int unsigned SECT_US = 25000,
  parameter int unsigned CHIP_US = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        start_op,
  input logic [DATA_W-1:0] start_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy
);
  localparam int unsigned P_CYC = int'((64'(CLK_KHZ) * 64'(PROG_US)) / 64'd1000);
  localparam int unsigned S_CYC = int'((64'(CLK_KHZ) * 64'(SECT_US)) / 64'd1000);
  localparam int unsigned C_CYC = int'((64'(CLK_KHZ) * 64'(CHIP_US)) / 64'd1000);

  logic              acc;
  logic [1:0]        op_q;
  logic              d7_q;
  logic [31:0]       run;
  logic [31:0]       exp_len;
  logic              rv_busy, rv_idle, seen, prev6;
  logic [DATA_W-1:0] arr_q;

  assign acc = start && !busy;
  assign exp_len = (op_q == 2'd0) ? P_CYC : (op_q == 2'd1) ? S_CYC : C_CYC;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0; d7_q <= 1'b0; run <= '0;
      rv_busy <= 1'b0; rv_idle <= 1'b0; seen <= 1'b0; prev6 <= 1'b0;
      arr_q <= '0;
    end else begin
      rv_busy <= rd_en && busy;
      rv_idle <= rd_en && !busy;
      arr_q   <= arr_data;
      if (acc) begin
        op_q <= start_op;
        d7_q <= start_data[7];
        run  <= '0;
        seen <= 1'b0;
      end else begin
        if (busy) run <= run + 1;
        if (rv_busy) begin
          seen  <= 1'b1;
          prev6 <= rd_data[6];
        end
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (!busy && rd_data == '0));
  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
    (rv_busy && op_q == 2'd0) |-> (rd_data[7] == ~d7_q));
  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (rst)
    (rv_busy && op_q != 2'd0) |-> (rd_data[7] == 1'b0));
  assert_tog_first_R4: assert property (@(posedge clk) disable iff (rst)
    (rv_busy && !seen) |-> (rd_data[6] == 1'b0));
  assert_tog_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (rv_busy && seen) |-> (rd_data[6] != prev6));
  assert_low_pass_R5: assert property (@(posedge clk) disable iff (rst)
    rv_busy |-> (rd_data[5:0] == arr_q[5:0]));
  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_len_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < exp_len));
  assert_len_exact_R6_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == exp_len));
  assert_idle_pass_R8: assert property (@(posedge clk) disable iff (rst)
    rv_idle |-> (rd_data == arr_q));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind flash_wstat_gen fws_checker #(
  .DATA_W (DATA_W),
  .CLK_KHZ(CLK_KHZ),
  .PROG_US(PROG_US),
  .SECT_US(SECT_US),
  .CHIP_US(CHIP_US)
) u_fws_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_op  (start_op),
  .start_data(start_data),
  .rd_en     (rd_en),
  .arr_data  (arr_data),
  .rd_data   (rd_data),
  .busy      (busy)
);

// File: tb/flash_wstat_gen_test.sv
module flash_wstat_gen_test;
  localparam int CLK_KHZ = 1000;
  localparam int PROG_US = 7;
  localparam int SECT_US = 19;
  localparam int CHIP_US = 33;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [1:0] start_op;
  logic [7:0] start_data;
  logic       rd_en;
  logic [7:0] arr_data;
  logic [7:0] rd_data;
  logic       busy;

  int vectors = 0;
  int fails   = 0;

  // model state
  logic       m_busy, m_tog, m_prog, m_inv7;
  int         m_cnt;
  logic [7:0] m_rd;
  logic       last_rd, last_rd_busy;
  string      busy_tag;

  always #2 clk = ~clk;

  flash_wstat_gen #(
    .DATA_W(8), .CLK_KHZ(CLK_KHZ), .PROG_US(PROG_US),
    .SECT_US(SECT_US), .CHIP_US(CHIP_US)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .start_data(start_data), .rd_en(rd_en), .arr_data(arr_data),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic int dur(input logic [1:0] op);
    case (op)
      2'd0:    return CLK_KHZ * PROG_US / 1000;
      2'd1:    return CLK_KHZ * SECT_US / 1000;
      default: return CLK_KHZ * CHIP_US / 1000;
    endcase
  endfunction

  function automatic logic [7:0] status_word(input logic prog, input logic inv7,
                                             input logic tog, input logic [7:0] arr);
    return {prog ? inv7 : 1'b0, tog, arr[5:0]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic [1:0] op, input logic [7:0] d,
                      input logic re, input logic [7:0] arr);
    logic acc;
    start = st; start_op = op; start_data = d; rd_en = re; arr_data = arr;
    @(posedge clk);
    acc = st && !m_busy;
    last_rd = re;
    last_rd_busy = m_busy;
    if (re) m_rd = m_busy ? status_word(m_prog, m_inv7, m_tog, arr) : arr;
    if (acc) begin
      m_tog = 1'b0; m_prog = (op == 2'd0); m_inv7 = ~d[7];
      m_busy = 1'b1; m_cnt = dur(op) - 1;
    end else begin
      if (re && m_busy) m_tog = ~m_tog;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 1'b0;
        else m_cnt--;
      end
    end
    @(negedge clk);
    check(busy_tag, int'(busy), int'(m_busy));
    if (!last_rd) check("R9 hold", int'(rd_data), int'(m_rd));
    else if (!last_rd_busy) check("R8 idle read", int'(rd_data), int'(m_rd));
    else begin
      check(m_prog ? "R2 program poll bit" : "R3 erase poll bit",
            int'(rd_data[7]), int'(m_rd[7]));
      check("R4 toggle bit", int'(rd_data[6]), int'(m_rd[6]));
      check("R5 low bits", int'(rd_data[5:0]), int'(m_rd[5:0]));
    end
  endtask

  task automatic idle(input int n, input logic re, input logic [7:0] arr);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00, re, arr);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] d);
    step(1'b1, op, d, 1'b0, 8'h00);
    for (int i = 0; i < dur(op) + 2; i++)
      step(1'b0, 2'd0, 8'h00, 1'b1, 8'($urandom()));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    busy_tag = "R6 busy";
    m_busy = 0; m_tog = 0; m_prog = 0; m_inv7 = 0; m_cnt = 0; m_rd = 8'h00;
    rst = 1'b1; start = 0; start_op = 0; start_data = 0; rd_en = 1'b1; arr_data = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset data", int'(rd_data), 0);
    rst = 1'b0;
    idle(3, 1'b0, 8'h00);
    idle(2, 1'b1, 8'hA7);              // R8 plain reads

    run_op(2'd0, 8'h80);               // R2 bit7 reads 0
    run_op(2'd0, 8'h3C);               // R2 bit7 reads 1
    step(1'b1, 2'd1, 8'h00, 1'b0, 8'h00);   // R3 sector erase
    for (int i = 0; i < dur(2'd1) + 2; i++) step(1'b0, 2'd0, 8'h00, 1'b1, 8'hFF);
    check("R8 erased byte", int'(rd_data), 8'hFF);
    run_op(2'd3, 8'h00);               // R3 chip erase, alternate code

    // R7: repeated starts during a program are ignored
    busy_tag = "R7 busy";
    step(1'b1, 2'd0, 8'h00, 1'b1, 8'h11);
    step(1'b0, 2'd0, 8'h00, 1'b1, 8'h22);
    step(1'b1, 2'd2, 8'hFF, 1'b1, 8'h33);
    step(1'b1, 2'd1, 8'hFF, 1'b0, 8'h44);
    for (int i = 0; i < dur(2'd0) + 2; i++) step(1'b1, 2'd1, 8'h80, 1'b1, 8'($urandom()));
    busy_tag = "R6 busy";

    // R4: reads with gaps keep alternating only on reads
    step(1'b1, 2'd2, 8'h00, 1'b0, 8'h00);
    for (int i = 0; i < dur(2'd2) + 2; i++) step(1'b0, 2'd0, 8'h00, i[1], 8'hC3);

    // random mix
    for (int i = 0; i < 6000; i++)
      step(($urandom() % 23) == 0, 2'($urandom()), 8'($urandom()),
           1'($urandom()), 8'($urandom()));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule